// File: doc/BRIEF.md
# Serial NOR Flash Read and Identification Responder

This block is a SPI target in mode 0 that behaves like a small serial NOR flash as seen from a host controller. It answers two commands: a byte-stream read and a read-identification query. The clock, select and data pins are oversampled by the system clock. The memory is a read-only array inside the block, filled with a computed pattern and laid out so that an FPGA block RAM can hold it.

A read presents a 24-bit address, but the array holds only `MEM_DEPTH` bytes. The block uses only the low address bits, so every higher address returns the same data as the matching lower one. The identification reply gives a manufacturer code, a device code and a density byte `n`, which claims a device size of 2^n bytes. Any other opcode leaves the data-out pin quiet until the select line is released. Releasing the select line at any point ends the command.

Top module: `spi_flash_resp`

## Requirements
- R1: While `spi_cs_n` is high, and after reset, `spi_miso` is 0.
- R2: After select falls, the first byte is the opcode. Opcode 0x03 is followed by three address bytes, most significant byte first. Data then starts at that address, with the first bit driven after the falling SCLK edge that ends the last address bit.
- R3: During a read, bytes keep streaming while clocks continue. The address advances by one after each byte.
- R4: The array index is the address modulo `MEM_DEPTH` (1024 by default), so data mirrors every 0x400 bytes. Advancing past index 0x3FF wraps to 0x000.
- R5: Opcode 0x9F returns three bytes: manufacturer code (default 0x5A), then device code (default 0x31), then density code (default 0x16, which claims 2^0x16 bytes). Every later byte in the same select is 0x00.
- R6: Any opcode other than 0x03 or 0x9F gives 0 on `spi_miso` for the rest of that select. The next select is decoded normally.
- R7: A rising `spi_cs_n` aborts any command, including one stopped part way through a byte. The next select starts again at the opcode.
- R8: `spi_miso` is 0 during the opcode byte and the three address bytes.
- R9: Bits are shifted MSB first. `spi_miso` changes only after a falling SCLK edge or on deselect, so it is stable while SCLK is high. MOSI is sampled on the rising edge.
- R10: The array byte at index i is (37*i + floor(i/256)) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | Host-to-target data |
| spi_miso | output | 1 | Target-to-host data, registered |

## Verification
A bit counter that is off by one shows within one byte. Every later byte arrives rotated, and the command bytes themselves are decoded wrongly, so an opcode can be misread and push the block into the silent state. An address register that keeps too many bits, or wraps wrongly, shows only when a read starts near 0x3FF or above 0x3FF. For that reason the bench reads across the mirror boundary and at high addresses, where the pattern's upper term tells the mirrored copies apart. A state machine that survives deselect shows on the first byte of the next select: a stale data bit or a misplaced opcode decode appears at once.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam int ADDR_BYTES = 3;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_ID,
    ST_MUTE
  } resp_state_t;

  function automatic logic [7:0] fill_byte(input int unsigned idx);
    int unsigned v;
    v = idx * 37 + (idx >> 8);
    return v[7:0];
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_in,
  input  logic sclk_in,
  input  logic mosi_in,
  output logic cs_idle,
  output logic mosi_s,
  output logic sclk_rise,
  output logic sclk_fall
);
  logic [1:0] cs_q;
  logic [1:0] mosi_q;
  logic [2:0] sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q      <= 2'b11;
      mosi_q    <= 2'b00;
      sclk_q    <= 3'b000;
      cs_idle   <= 1'b1;
      mosi_s    <= 1'b0;
      sclk_rise <= 1'b0;
      sclk_fall <= 1'b0;
    end else begin
      cs_q      <= {cs_q[0], cs_n_in};
      mosi_q    <= {mosi_q[0], mosi_in};
      sclk_q    <= {sclk_q[1:0], sclk_in};
      cs_idle   <= cs_q[1];
      mosi_s    <= mosi_q[1];
      sclk_rise <= sclk_q[1] & ~sclk_q[2];
      sclk_fall <= ~sclk_q[1] & sclk_q[2];
    end
  end
endmodule

// File: rtl/flash_rom.sv
module flash_rom #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  import spi_flash_pkg::*;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = fill_byte(i);
  end

  always_ff @(posedge clk) q <= mem[addr];
endmodule

// File: rtl/spi_flash_resp.sv
module spi_flash_resp #(
  parameter int         MEM_DEPTH    = 1024,
  parameter logic [7:0] MFR_CODE     = 8'h5A,
  parameter logic [7:0] DEV_CODE     = 8'h31,
  parameter logic [7:0] DENSITY_CODE = 8'h16
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_cs_n,
  input  logic spi_sclk,
  input  logic spi_mosi,
  output logic spi_miso
);
  import spi_flash_pkg::*;

  localparam int AW = $clog2(MEM_DEPTH);

  logic cs_idle, mosi_s, rise, fall;
  resp_state_t state;
  logic [2:0]    bit_cnt;
  logic [6:0]    rx_sr;
  logic [6:0]    tx_sr;
  logic [1:0]    abyte;
  logic [1:0]    id_idx;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rom_q;
  logic [7:0]    rx_byte;
  logic [7:0]    id_byte;
  logic [7:0]    nxt_byte;

  spi_pin_sync sync_i (
    .clk(clk), .rst(rst),
    .cs_n_in(spi_cs_n), .sclk_in(spi_sclk), .mosi_in(spi_mosi),
    .cs_idle(cs_idle), .mosi_s(mosi_s),
    .sclk_rise(rise), .sclk_fall(fall)
  );

  flash_rom #(.DEPTH(MEM_DEPTH)) rom_i (
    .clk(clk), .addr(rd_addr), .q(rom_q)
  );

  assign rx_byte = {rx_sr, mosi_s};

  always_comb begin
    case (id_idx)
      2'd0:    id_byte = MFR_CODE;
      2'd1:    id_byte = DEV_CODE;
      2'd2:    id_byte = DENSITY_CODE;
      default: id_byte = 8'h00;
    endcase
    nxt_byte = (state == ST_DATA) ? rom_q : id_byte;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_idle) begin
      state    <= ST_OPC;
      bit_cnt  <= '0;
      abyte    <= '0;
      id_idx   <= '0;
      spi_miso <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      if (rst) rd_addr <= '0;
    end else begin
      if (rise) begin
        rx_sr   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          case (state)
            ST_OPC: begin
              if (rx_byte == OP_READ)      state <= ST_ADDR;
              else if (rx_byte == OP_RDID) state <= ST_ID;
              else                         state <= ST_MUTE;
            end
            ST_ADDR: begin
              rd_addr <= AW'({rd_addr, rx_byte});
              abyte   <= abyte + 2'd1;
              if (abyte == 2'(ADDR_BYTES - 1)) state <= ST_DATA;
            end
            default: ;
          endcase
        end
      end
      if (fall) begin
        if (state == ST_DATA || state == ST_ID) begin
          if (bit_cnt == 3'd0) begin
            spi_miso <= nxt_byte[7];
            tx_sr    <= nxt_byte[6:0];
            if (state == ST_DATA) rd_addr <= rd_addr + 1'b1;
            if (state == ST_ID && id_idx != 2'd3) id_idx <= id_idx + 2'd1;
          end else begin
            spi_miso <= tx_sr[6];
            tx_sr    <= {tx_sr[5:0], 1'b0};
          end
        end else begin
          spi_miso <= 1'b0;
        end
      end
    end
  end

  // R1: deselect forces the data line low on the next cycle
  assert_miso_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> (spi_miso == 1'b0));

  // R7: deselect returns the decoder to the opcode phase with a clean bit count
  assert_abort_reset_R7: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> (state == ST_OPC && bit_cnt == 3'd0));

  // R8: the line stays quiet through opcode and address bytes
  assert_cmd_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPC || state == ST_ADDR) |-> (spi_miso == 1'b0));

  // R6: an unknown opcode keeps the line quiet
  assert_mute_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MUTE) |-> (spi_miso == 1'b0));

  // R9: the output moves only after a falling SCLK edge or a deselect
  assert_miso_edge_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_miso) |-> $past(fall || cs_idle));

  // R5: the identification index saturates after the density byte
  assert_id_sat_R5: assert property (@(posedge clk) disable iff (rst)
    (id_idx == 2'd3) |=> (id_idx == 2'd3 || cs_idle || $past(cs_idle)));
endmodule

// File: tb/spi_flash_resp_tb_top.sv
module spi_flash_resp_tb_top;
  localparam int HALF = 10;
  localparam int DEPTH = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];

  always #5 clk = ~clk;

  spi_flash_resp dut_i (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sclk(sclk),
    .spi_mosi(mosi), .spi_miso(miso)
  );

  function automatic logic [7:0] model_byte(input int unsigned a);
    int unsigned i;
    i = a % DEPTH;
    return 8'(((i * 37) + (i / 256)) % 256);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: exchanges one byte, pushes the expected reply to the scoreboard.
  task automatic xfer(input logic [7:0] tx, input logic [7:0] exp, input string req);
    logic [7:0] rx;
    bit stable_ok;
    stable_ok = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      wait_clk(HALF);
      rx[b] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      if (miso != rx[b]) stable_ok = 1'b0;
      sclk = 1'b0;
    end
    got_q.push_back(rx);
    check(stable_ok, "R9 miso stable while sclk high", int'(stable_ok), 1);
  endtask

  task automatic select();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic deselect();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(12);
    check(miso == 1'b0, "R1 miso low when deselected", int'(miso), 0);
  endtask

  task automatic read_seq(input logic [23:0] addr, input int n, input string req);
    select();
    xfer(8'h03, 8'h00, "R8 opcode phase quiet");
    xfer(addr[23:16], 8'h00, "R8 address phase quiet");
    xfer(addr[15:8],  8'h00, "R8 address phase quiet");
    xfer(addr[7:0],   8'h00, "R8 address phase quiet");
    for (int k = 0; k < n; k++)
      xfer(8'h00, model_byte(int'(addr) + k), req);
    deselect();
  endtask

  // Monitor: pops expected items and compares against captured replies.
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g == e, t, int'(g), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    check(miso == 1'b0, "R1 reset state", int'(miso), 0);

    read_seq(24'h000000, 4, "R2 R10 read from zero");
    read_seq(24'h000123, 3, "R2 R3 read mid array");
    read_seq(24'h0003FE, 4, "R4 wrap past top index");
    read_seq(24'h012345, 3, "R4 mirrored high address");
    read_seq(24'hFFFFFF, 2, "R4 top of address space");
    read_seq(24'h0000F0, 40, "R3 long burst");

    select();
    xfer(8'h9F, 8'h00, "R8 opcode phase quiet");
    xfer(8'h00, 8'h5A, "R5 manufacturer code");
    xfer(8'h00, 8'h31, "R5 device code");
    xfer(8'h00, 8'h16, "R5 density code");
    xfer(8'h00, 8'h00, "R5 after id bytes");
    deselect();

    select();
    xfer(8'hAB, 8'h00, "R6 unknown opcode");
    for (int k = 0; k < 4; k++) xfer(8'hFF, 8'h00, "R6 unknown opcode silent");
    deselect();
    read_seq(24'h000200, 2, "R6 decode after unknown");

    // R7: abort part way through an address byte
    select();
    xfer(8'h03, 8'h00, "R8 opcode phase quiet");
    xfer(8'h00, 8'h00, "R8 address phase quiet");
    for (int b = 0; b < 4; b++) begin
      mosi = 1'b1;
      wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    deselect();
    read_seq(24'h000010, 2, "R7 read after aborted address");

    // R7: abort during data, then identification must start cleanly
    select();
    xfer(8'h03, 8'h00, "R8 opcode phase quiet");
    xfer(8'h00, 8'h00, "R8 address phase quiet");
    xfer(8'h00, 8'h00, "R8 address phase quiet");
    xfer(8'h05, 8'h00, "R8 address phase quiet");
    xfer(8'h00, model_byte(5), "R2 data before abort");
    for (int b = 0; b < 3; b++) begin
      wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    deselect();
    select();
    xfer(8'h9F, 8'h00, "R7 opcode after data abort");
    xfer(8'h00, 8'h5A, "R7 id after data abort");
    deselect();

    wait_clk(20);
    done = 1'b1;
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule